// File: doc/BRIEF.md
# Card Clock Divider with Glitch-Free Ratio Switching

This block derives the clock driven to a smart-card contact from a faster input clock. A 2-bit select picks a division ratio of 1, 2, 4 or 8. A gate input from the card sequencer starts and stops the card clock. When the gate is off, the output is held low.

The ratio and the gate are never applied in the middle of an output period. Both are sampled, and take effect, only at the rising input edge that ends a complete output period. At that edge the current period has just finished its full low phase. The new period then starts at phase zero with its high phase. As a result, every high and low phase around a switch keeps its full width.

A request that flips both select bits at once is split into two single-bit steps. The low bit is flipped first, so the intermediate ratio runs for one full period. Divide by 1 passes the input clock through a latch-based clock gate. Its enable is only updated while the input clock is low, so the first and last pulses are always complete input-clock high phases.

Top module: `cardclk_divider`

## Requirements
- R1: The select encoding is 2'b00 for divide by 8, 2'b01 for divide by 4, 2'b10 for divide by 2 and 2'b11 for divide by 1. While running at ratio N >= 2, the output is high for the first N/2 input cycles of each N-cycle period and low for the rest. While running at divide by 1, the output follows the input clock.
- R2: A new select value is taken only at the rising edge that ends a complete output period. The output period that follows starts with its high phase.
- R3: Around a ratio switch, no high or low phase is shorter than half of the smaller period involved. The pulse just before the switch and the pulse just after it keep their correct widths.
- R4: If both select bits differ from the active ratio, the low bit is flipped first. That intermediate ratio runs for one full output period before the target ratio is taken at the next period end.
- R5: When the gate is low, the output is held low. A gate drop takes effect only at the end of the current period, so the last pulse is complete.
- R6: A gate rise while stopped is taken at the next rising edge. For N >= 2, the output goes high right after that edge. For divide by 1, the first pulse comes one input cycle later.
- R7: A synchronous reset stops the output (held low), selects divide by 8 and clears the phase.
- R8: Divide-by-1 pulses are whole input-clock high phases. The enable is never updated while the input clock is high, and the registered divided path stays low while divide by 1 is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous reset, active high |
| sel_i | input | 2 | Ratio select (00 = /8, 01 = /4, 10 = /2, 11 = /1) |
| gate_i | input | 1 | Card clock enable from the sequencer |
| cclk_o | output | 1 | Divided, gated card clock |

## Verification
Select and gate are sampled at a rising edge and act only at the period-ending edge. For ratios of 2 and above, the output level changes directly after that edge. For divide by 1, the first pulse appears one rising edge later, and the last pulse is the high half right after the stopping edge. The bench changes inputs on falling edges and updates its reference model on each rising edge. It compares the output twice per input cycle: 1 ns after the rising edge (high half) and 1 ns after the falling edge (low half). Each level is therefore judged in the half cycle where it is due, and never at an edge.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

  // Largest ratio is 2**DIV_LOG_MAX; the phase counter spans it.
  localparam int DIV_LOG_MAX = 3;
  localparam int PH_W        = DIV_LOG_MAX;

  typedef logic [1:0] ratio_sel_t;

  localparam ratio_sel_t SEL_DIV8 = 2'b00;
  localparam ratio_sel_t SEL_DIV1 = 2'b11;

  // Division ratio for a select code: 8 >> code.
  function automatic int unsigned ratio_of(ratio_sel_t s);
    return (32'd1 << DIV_LOG_MAX) >> s;
  endfunction

  // Phase index of the final input cycle of a period.
  function automatic logic [PH_W-1:0] last_phase(ratio_sel_t s);
    return PH_W'(ratio_of(s) - 32'd1);
  endfunction

  // Number of input cycles the output spends high in a period (0 for /1).
  function automatic logic [PH_W-1:0] high_len(ratio_sel_t s);
    return PH_W'(ratio_of(s) >> 1);
  endfunction

  // One legal step from the active code toward the requested one:
  // a double-bit change moves the low bit first.
  function automatic ratio_sel_t step_toward(ratio_sel_t cur, ratio_sel_t req);
    if ((cur ^ req) == 2'b11) return cur ^ 2'b01;
    return req;
  endfunction

endpackage

// File: rtl/cardclk_phase.sv
module cardclk_phase
  import cardclk_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_i,
  input  ratio_sel_t      sel_i,
  input  logic            gate_i,
  output ratio_sel_t      act_o,
  output logic            run_o,
  output logic [PH_W-1:0] ph_o,
  output logic            bnd_o,
  output logic            divq_o,
  output logic            g1en_o
);

  ratio_sel_t      act_q, act_n;
  logic            run_q, run_n;
  logic [PH_W-1:0] ph_q, ph_n;
  logic            divq_q, divq_n;
  logic            g1en_q, g1en_n;
  logic            bnd;

  // A period boundary: the last input cycle of a period, or any cycle while stopped.
  assign bnd = !run_q || (ph_q == last_phase(act_q));

  always_comb begin
    if (bnd) begin
      run_n = gate_i;
      act_n = step_toward(act_q, sel_i);
      ph_n  = '0;
    end else begin
      run_n = run_q;
      act_n = act_q;
      ph_n  = ph_q + PH_W'(1);
    end
    divq_n = run_n && (act_n != SEL_DIV1) && (ph_n < high_len(act_n));
    g1en_n = run_n && (act_n == SEL_DIV1);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q  <= 1'b0;
      act_q  <= SEL_DIV8;
      ph_q   <= '0;
      divq_q <= 1'b0;
      g1en_q <= 1'b0;
    end else begin
      run_q  <= run_n;
      act_q  <= act_n;
      ph_q   <= ph_n;
      divq_q <= divq_n;
      g1en_q <= g1en_n;
    end
  end

  assign act_o  = act_q;
  assign run_o  = run_q;
  assign ph_o   = ph_q;
  assign bnd_o  = bnd;
  assign divq_o = divq_q;
  assign g1en_o = g1en_q;

endmodule

// File: rtl/cardclk_gate.sv
module cardclk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);

  logic en_lat;

  // Enable captured only while the clock is low, so a pulse is never cut.
  always_latch begin
    if (!clk_i) en_lat = en_i;
  end

  assign gclk_o = clk_i & en_lat;

endmodule

// File: rtl/cardclk_divider.sv
module cardclk_divider
  import cardclk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [1:0] sel_i,
  input  logic       gate_i,
  output logic       cclk_o
);

  ratio_sel_t      act;
  logic            run;
  logic [PH_W-1:0] ph;
  logic            bnd;
  logic            divq;
  logic            g1en;
  logic            gclk;

  cardclk_phase u_phase (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .sel_i  (sel_i),
    .gate_i (gate_i),
    .act_o  (act),
    .run_o  (run),
    .ph_o   (ph),
    .bnd_o  (bnd),
    .divq_o (divq),
    .g1en_o (g1en)
  );

  cardclk_gate u_gate (
    .clk_i  (clk_i),
    .en_i   (g1en),
    .gclk_o (gclk)
  );

  // The two paths are never active together, so an OR is glitch-free.
  assign cclk_o = divq | gclk;

endmodule

// File: rtl/cardclk_divider_chk.sv
module cardclk_divider_chk
  import cardclk_pkg::*;
(
  input logic            clk_i,
  input logic            rst_i,
  input ratio_sel_t      act,
  input logic            run,
  input logic [PH_W-1:0] ph,
  input logic            bnd,
  input logic            divq,
  input logic            g1en
);

  AST_RST_QUIET: assert property (@(posedge clk_i)
    rst_i |=> (!run && !divq && !g1en && act == SEL_DIV8 && ph == '0)); // R7

  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    run |-> (ph <= last_phase(act))); // R1

  AST_RATIO_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !bnd |=> $stable(act)); // R2

  AST_RISE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (rst_i)
    !bnd |=> !$rose(divq)); // R3

  AST_ONE_BIT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    bnd |=> ($countones(act ^ $past(act)) <= 1)); // R4

  AST_GATE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !bnd |=> $stable(run)); // R5

  AST_STOPPED_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
    !run |-> (!divq && !g1en)); // R5

  AST_DIV1_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
    g1en |-> !divq); // R8

endmodule

bind cardclk_divider cardclk_divider_chk u_chk (
  .clk_i (clk_i),
  .rst_i (rst_i),
  .act   (act),
  .run   (run),
  .ph    (ph),
  .bnd   (bnd),
  .divq  (divq),
  .g1en  (g1en)
);

// File: tb/tb_cardclk_divider.sv
`timescale 1ns/1ps
module tb_cardclk_divider;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel = 2'b00;
  logic       gate = 1'b0;
  logic       cclk;

  int    vectors = 0;
  int    miscompares = 0;
  bit    chk_en = 1'b0;
  string cur_req = "R7";

  // Behavioural reference state
  int m_run = 0;
  int m_ratio = 8;
  int m_pos = 0;
  bit exp_hi = 1'b0;
  bit exp_lo = 1'b0;

  always #2 clk = ~clk;

  cardclk_divider dut (
    .clk_i  (clk),
    .rst_i  (rst),
    .sel_i  (sel),
    .gate_i (gate),
    .cclk_o (cclk)
  );

  function automatic int ratio_for_code(int code);
    case (code)
      0: return 8;
      1: return 4;
      2: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int code_for_ratio(int r);
    case (r)
      8: return 0;
      4: return 1;
      2: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic check(bit got, bit exp, string which);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t (%s half): got %b expected %b", cur_req, $time, which, got, exp);
    end
  endtask

  // Reference model: one update per rising edge, two comparisons per cycle.
  always begin
    bit was_fast;
    int cur_code, req_code, diff;
    @(posedge clk);
    was_fast = (m_run != 0) && (m_ratio == 1);
    if (rst) begin
      m_run = 0; m_ratio = 8; m_pos = 0;
    end else if (m_run == 0 || m_pos == m_ratio - 1) begin
      cur_code = code_for_ratio(m_ratio);
      req_code = int'(sel);
      diff = $countones(2'(cur_code) ^ 2'(req_code));
      if (diff == 2) req_code = (cur_code & 2) | ((cur_code & 1) ^ 1);
      m_ratio = ratio_for_code(req_code);
      m_run = gate ? 1 : 0;
      m_pos = 0;
    end else begin
      m_pos++;
    end
    exp_lo = (m_run != 0) && (m_ratio > 1) && (m_pos * 2 < m_ratio);
    exp_hi = exp_lo || was_fast;
    #1;
    if (chk_en) check(cclk, exp_hi, "high");
    #2;
    if (chk_en) check(cclk, exp_lo, "low");
  end

  task automatic drive(bit g, logic [1:0] s);
    @(negedge clk);
    gate = g;
    sel = s;
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    chk_en = 1'b1;
    cur_req = "R7";
    cycles(2);
    @(negedge clk); rst = 1'b0;
    cycles(3);

    // R6: start from stopped, /8
    cur_req = "R6";
    drive(1'b1, 2'b00); cycles(20);
    // R1: each ratio in single-bit order
    cur_req = "R1";
    drive(1'b1, 2'b01); cycles(17);
    drive(1'b1, 2'b11); cycles(9);
    drive(1'b1, 2'b10); cycles(11);
    // R4: double-bit requests
    cur_req = "R4";
    drive(1'b1, 2'b01); cycles(13);
    drive(1'b1, 2'b10); cycles(21);
    drive(1'b1, 2'b00); cycles(5);
    drive(1'b1, 2'b11); cycles(25);
    drive(1'b1, 2'b00); cycles(23);
    // R3 / R2: switches between distant ratios at odd offsets
    cur_req = "R3";
    drive(1'b1, 2'b10); cycles(9);
    drive(1'b1, 2'b00); cycles(3);
    cur_req = "R2";
    drive(1'b1, 2'b01); cycles(19);
    cur_req = "R8";
    drive(1'b1, 2'b11); cycles(7);
    drive(1'b1, 2'b01); cycles(14);
    // R5: stop in /8 mid-period, then in /1
    cur_req = "R5";
    drive(1'b1, 2'b00); cycles(11);
    drive(1'b0, 2'b00); cycles(14);
    cur_req = "R6";
    drive(1'b1, 2'b11); cycles(6);
    cur_req = "R5";
    drive(1'b0, 2'b11); cycles(6);
    drive(1'b1, 2'b01); cycles(5);
    drive(1'b0, 2'b01); cycles(8);
    // R7: reset while running at /1
    cur_req = "R7";
    drive(1'b1, 2'b11); cycles(6);
    @(negedge clk); rst = 1'b1;
    cycles(3);
    @(negedge clk); rst = 1'b0; gate = 1'b0;
    cycles(4);

    @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule